// File: doc/BRIEF.md
# Address Translation Cache with Hardware Table Walk

This block translates 32-bit virtual addresses for one memory side, either the instruction side or the data side. It keeps a small fully associative set of recent translations. A request that finds a matching translation returns a physical address, a cacheable flag and a fault code one clock later. A request that finds no match starts a hardware walk of a two-level page table. The walk reads descriptors through a single-word memory read port. A good walk installs the new translation and answers the request.

One table holds both page sizes. A first-level descriptor either maps a 4 MB section directly or points to a second-level table of 4 KB pages. Every translation carries four attributes: global, locked, cacheable and executable. A locked translation survives a flush-all and is never chosen for replacement. Software controls the block through a small control port. It can load the table base, flush the unlocked translations and set or clear the lock bit of any slot. The block only reports faults. Vectoring to a handler is the job of the core.

Top module: `tlbw_top`

## Requirements
- R1: After reset, every slot is invalid and unlocked, `req_ready` is 1, and both `resp_valid` and `mem_req` are 0.
- R2: A request accepted while `req_valid` and `req_ready` are both high, and that matches a slot, gives a one-cycle `resp_valid` pulse on the next clock edge. It makes no memory read.
- R3: A 4 MB slot compares only VA[31:22] and returns {frame[31:22], VA[21:0]}. A 4 KB slot compares VA[31:12] and returns {frame[31:12], VA[11:0]}.
- R4: A slot matches only when it is valid and either its global attribute is set or its stored address-space ID equals `req_asid`.
- R5: On a miss the first read goes to {base[31:12], VA[31:22], 2'b00}. Descriptor bits are: bit 0 valid, bit 1 section (1 = 4 MB leaf, 0 = table pointer), bit 2 cacheable, bit 3 executable, bit 4 global. A leaf holds its frame in [31:22].
- R6: For a table pointer, the second read goes to {desc[31:12], VA[21:12], 2'b00}. The second-level descriptor uses bits 0, 2, 3 and 4 as in R5 and holds a 4 KB frame in [31:12].
- R7: A descriptor whose valid bit is 0 ends the walk with fault code 1, PA 0 and cacheable 0. No slot is written, so the same address walks again.
- R8: A fetch (`req_fetch` = 1) to a translation without the executable attribute returns fault code 2 with PA 0. A data access to the same page translates normally. Fault code 0 means no fault.
- R9: A good walk installs its translation with the request's address-space ID. The slot is chosen round-robin: the first unlocked slot at or after a rotating pointer, which then moves past it.
- R10: When every slot is locked, a good walk still answers the request but installs nothing.
- R11: A one-cycle `ctl_flush` invalidates every unlocked slot. Locked slots keep their translations.
- R12: `mem_addr` and `mem_req` stay steady from the cycle a read is issued until `mem_ack` is high. `mem_rdata` is taken in the cycle `mem_ack` is high.
- R13: `ctl_base_we` loads the table base from `ctl_base`. Bits [11:0] of the base are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_asid | input | ASID_W | Current address-space ID |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_pa | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 2 | 0 none, 1 translation, 2 execute |
| resp_cacheable | output | 1 | Cacheable attribute |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| ctl_base_we | input | 1 | Load table base |
| ctl_base | input | 32 | Table base value |
| ctl_flush | input | 1 | Flush unlocked slots |
| ctl_lock_we | input | 1 | Write one lock bit |
| ctl_lock_idx | input | IDX_W | Slot whose lock bit is written |
| ctl_lock_val | input | 1 | Lock bit value |

## Verification
The bench builds the block with its defaults: 16 slots and 8-bit address-space IDs. With 16 slots, a few dozen requests are enough to fill every slot, wrap the round-robin pointer past a locked slot, evict a chosen translation and then lock the whole table. A model memory answers each descriptor read one cycle late, so the address-hold rule applies on every read. The number of reads per request shows at the ports whether a request hit, walked one level or walked two levels.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

  localparam int DB_VALID  = 0;
  localparam int DB_SECT   = 1;
  localparam int DB_CACHE  = 2;
  localparam int DB_EXEC   = 3;
  localparam int DB_GLOBAL = 4;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_EXEC  = 2'd2
  } fault_e;

  typedef struct packed {
    logic glob;
    logic cache;
    logic exec;
  } attr_t;

  typedef struct packed {
    logic        big;
    logic [19:0] vpn;
    logic [19:0] ppn;
    attr_t       attr;
  } xlat_t;

  function automatic logic [31:0] form_pa(input xlat_t e, input logic [31:0] va);
    return e.big ? {e.ppn[19:10], va[21:0]} : {e.ppn, va[11:0]};
  endfunction

endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output xlat_t             lk_ent,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  xlat_t             fill_ent,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              flush,
  input  logic              lock_we,
  input  logic [IDX_W-1:0]  lock_idx,
  input  logic              lock_val,
  output logic [ENTRIES-1:0] lock_vec
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] lock_q;
  logic [ENTRIES-1:0] match;
  xlat_t              ent_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];

  assign lock_vec = lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      lock_q  <= '0;
    end else begin
      if (flush) valid_q <= valid_q & lock_q;
      if (lock_we) lock_q[lock_idx] <= lock_val;
      if (fill_we) valid_q[fill_idx] <= 1'b1;
    end
  end

  // payload storage kept free of reset
  always_ff @(posedge clk) begin
    if (fill_we) begin
      ent_q[fill_idx]  <= fill_ent;
      asid_q[fill_idx] <= fill_asid;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic own_space, tag_eq;
    assign own_space = ent_q[g].attr.glob || (asid_q[g] == lk_asid);
    assign tag_eq    = ent_q[g].big ? (ent_q[g].vpn[19:10] == lk_va[31:22])
                                    : (ent_q[g].vpn == lk_va[31:12]);
    assign match[g]  = valid_q[g] && own_space && tag_eq;

    AST_LOCK_SURVIVES_FLUSH: assert property (@(posedge clk) disable iff (rst)
      (flush && lock_q[g] && valid_q[g]) |=> valid_q[g]); // R11
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ent = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit = 1'b1;
        lk_ent = ent_q[i];
      end
    end
  end

  AST_FILL_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> !lock_q[fill_idx]); // R10

endmodule

// File: rtl/tlbw_victim.sv
module tlbw_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] lock_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim,
  output logic               victim_ok
);

  localparam logic [IDX_W:0] LIMIT = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    victim_ok = 1'b0;
    victim    = ptr_q;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      logic [IDX_W:0] s;
      s = {1'b0, ptr_q} + (IDX_W+1)'(k);
      if (s > LIMIT) s = s - (IDX_W+1)'(ENTRIES);
      if (!lock_vec[s[IDX_W-1:0]]) begin
        victim_ok = 1'b1;
        victim    = s[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q <= ({1'b0, victim} == LIMIT) ? '0 : victim + 1'b1;
    end
  end

endmodule

// File: rtl/tlbw_walk.sv
module tlbw_walk
  import tlbw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] start_va,
  input  logic [31:0] base,
  output logic        idle,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        done_fault,
  output xlat_t       done_ent
);

  typedef enum logic [1:0] {W_IDLE, W_L1, W_L2} wst_e;

  wst_e        st_q;
  logic [31:0] va_q;
  logic [31:0] addr_q;
  logic        desc_ok, desc_ptr;

  assign desc_ok  = mem_rdata[DB_VALID];
  assign desc_ptr = desc_ok && !mem_rdata[DB_SECT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= W_IDLE;
      va_q   <= '0;
      addr_q <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (start) begin
          va_q   <= start_va;
          addr_q <= {base[31:12], start_va[31:22], 2'b00};
          st_q   <= W_L1;
        end
        W_L1: if (mem_ack) begin
          if (desc_ptr) begin
            addr_q <= {mem_rdata[31:12], va_q[21:12], 2'b00};
            st_q   <= W_L2;
          end else begin
            st_q <= W_IDLE;
          end
        end
        W_L2: if (mem_ack) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign idle     = (st_q == W_IDLE);
  assign mem_req  = !idle;
  assign mem_addr = addr_q;

  always_comb begin
    done       = mem_ack && ((st_q == W_L2) || ((st_q == W_L1) && !desc_ptr));
    done_fault = !desc_ok;
    done_ent.big        = (st_q == W_L1);
    done_ent.vpn        = va_q[31:12];
    done_ent.ppn        = mem_rdata[31:12];
    done_ent.attr.glob  = mem_rdata[DB_GLOBAL];
    done_ent.attr.cache = mem_rdata[DB_CACHE];
    done_ent.attr.exec  = mem_rdata[DB_EXEC];
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R12

endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic              req_fetch,
  input  logic [ASID_W-1:0] req_asid,
  output logic              resp_valid,
  output logic [31:0]       resp_pa,
  output logic [1:0]        resp_fault,
  output logic              resp_cacheable,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              ctl_base_we,
  input  logic [31:0]       ctl_base,
  input  logic              ctl_flush,
  input  logic              ctl_lock_we,
  input  logic [IDX_W-1:0]  ctl_lock_idx,
  input  logic              ctl_lock_val
);

  logic [31:0]        base_q, va_q;
  logic               fetch_q;
  logic [ASID_W-1:0]  asid_q;
  logic               accept, lk_hit, walk_idle, walk_done, walk_fault;
  xlat_t              lk_ent, walk_ent;
  logic [ENTRIES-1:0] lock_vec;
  logic [IDX_W-1:0]   victim;
  logic               victim_ok, fill_we;

  assign req_ready = walk_idle;
  assign accept    = req_valid && walk_idle;
  assign fill_we   = walk_done && !walk_fault && victim_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      va_q    <= '0;
      fetch_q <= 1'b0;
      asid_q  <= '0;
    end else begin
      if (ctl_base_we) base_q <= {ctl_base[31:12], 12'h000};
      if (accept) begin
        va_q    <= req_va;
        fetch_q <= req_fetch;
        asid_q  <= req_asid;
      end
    end
  end

  tlbw_cam #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_cam (
    .clk(clk), .rst(rst),
    .lk_va(req_va), .lk_asid(req_asid), .lk_hit(lk_hit), .lk_ent(lk_ent),
    .fill_we(fill_we), .fill_idx(victim), .fill_ent(walk_ent), .fill_asid(asid_q),
    .flush(ctl_flush), .lock_we(ctl_lock_we), .lock_idx(ctl_lock_idx),
    .lock_val(ctl_lock_val), .lock_vec(lock_vec)
  );

  tlbw_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vic (
    .clk(clk), .rst(rst), .lock_vec(lock_vec), .advance(fill_we),
    .victim(victim), .victim_ok(victim_ok)
  );

  tlbw_walk u_walk (
    .clk(clk), .rst(rst),
    .start(accept && !lk_hit), .start_va(req_va), .base(base_q),
    .idle(walk_idle), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(walk_done), .done_fault(walk_fault), .done_ent(walk_ent)
  );

  // response source: hit on accept, or walk completion
  logic        src_go, src_fetch, src_bad;
  xlat_t       src_ent;
  logic [31:0] src_va;

  always_comb begin
    src_go    = 1'b0;
    src_ent   = walk_ent;
    src_va    = va_q;
    src_fetch = fetch_q;
    src_bad   = walk_fault;
    if (accept && lk_hit) begin
      src_go    = 1'b1;
      src_ent   = lk_ent;
      src_va    = req_va;
      src_fetch = req_fetch;
      src_bad   = 1'b0;
    end else if (walk_done) begin
      src_go = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid     <= 1'b0;
      resp_pa        <= '0;
      resp_fault     <= FLT_NONE;
      resp_cacheable <= 1'b0;
    end else begin
      resp_valid <= src_go;
      if (src_go) begin
        if (src_bad) begin
          resp_pa        <= '0;
          resp_fault     <= FLT_XLATE;
          resp_cacheable <= 1'b0;
        end else if (src_fetch && !src_ent.attr.exec) begin
          resp_pa        <= '0;
          resp_fault     <= FLT_EXEC;
          resp_cacheable <= 1'b0;
        end else begin
          resp_pa        <= form_pa(src_ent, src_va);
          resp_fault     <= FLT_NONE;
          resp_cacheable <= src_ent.attr.cache;
        end
      end
    end
  end

  AST_L1_INDEX: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (mem_addr[11:2] == $past(req_va[31:22]) &&
                        mem_addr[31:12] == base_q[31:12])); // R5
  AST_EXEC_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault == FLT_EXEC) |-> fetch_q); // R8

endmodule

// File: tb/sim_tlbw_top.sv
module sim_tlbw_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] L2T  = 32'h0020_0000;

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  code;
    logic        c;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = 8'd1;
  logic req_ready, resp_valid, resp_cacheable, mem_req;
  logic [31:0] resp_pa, mem_addr;
  logic [1:0]  resp_fault;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic ctl_base_we = 1'b0, ctl_flush = 1'b0, ctl_lock_we = 1'b0, ctl_lock_val = 1'b0;
  logic [31:0] ctl_base = '0;
  logic [3:0]  ctl_lock_idx = '0;

  int checks = 0, fails = 0, reads = 0, seen = 0;
  exp_t q[$];
  logic [31:0] pt [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbw_top u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_fetch(req_fetch), .req_asid(req_asid),
    .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_fault(resp_fault),
    .resp_cacheable(resp_cacheable), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ctl_base_we(ctl_base_we),
    .ctl_base(ctl_base), .ctl_flush(ctl_flush), .ctl_lock_we(ctl_lock_we),
    .ctl_lock_idx(ctl_lock_idx), .ctl_lock_val(ctl_lock_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // descriptor memory model: answers one cycle after the request
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= pt.exists(mem_addr) ? pt[mem_addr] : 32'h0;
      reads++;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // monitor: pops scoreboard on each response
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "unexpected response", resp_pa, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(resp_pa == e.pa, {e.tag, " pa"}, resp_pa, e.pa);
        chk(resp_fault == e.code && resp_cacheable == e.c, {e.tag, " fault/cacheable"},
            {29'd0, resp_fault, resp_cacheable}, {29'd0, e.code, e.c});
      end
      seen++;
    end
  end

  task automatic xlate(input logic [31:0] va, input logic f, input logic [7:0] asid,
                       input logic [31:0] epa, input logic [1:0] ecode, input logic ec,
                       input int ereads, input string tag);
    int r0, s0;
    exp_t e;
    r0 = reads;
    s0 = seen;
    e.pa = epa; e.code = ecode; e.c = ec; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_fetch = f; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    while (seen == s0) @(negedge clk);
    @(negedge clk);
    chk(reads - r0 == ereads, {tag, " read count"}, reads - r0, ereads);
  endtask

  task automatic set_lock(input int idx, input logic v);
    @(negedge clk);
    ctl_lock_we = 1'b1; ctl_lock_idx = 4'(idx); ctl_lock_val = v;
    @(negedge clk);
    ctl_lock_we = 1'b0;
  endtask

  task automatic flush_all();
    @(negedge clk);
    ctl_flush = 1'b1;
    @(negedge clk);
    ctl_flush = 1'b0;
  endtask

  function automatic logic [31:0] l2_desc(input int i);
    return 32'h9000_0000 + (i << 12) + 32'h1 + ((i % 2 == 0) ? 32'h4 : 32'h0)
         + ((i < 8) ? 32'h8 : 32'h0) + ((i == 3) ? 32'h10 : 32'h0);
  endfunction

  function automatic logic [31:0] pva(input int i, input int off);
    return 32'h0080_0000 + (i << 12) + off;
  endfunction

  function automatic logic [31:0] ppa(input int i, input int off);
    return 32'h9000_0000 + (i << 12) + off;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    pt[BASE + 32'd4] = 32'h8000_000F;        // VA[31:22]=1: 4 MB leaf, C, X
    pt[BASE + 32'd8] = L2T | 32'h1;          // VA[31:22]=2: table pointer
    for (int i = 0; i < 64; i++) pt[L2T + 32'(i * 4)] = l2_desc(i);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(resp_valid === 1'b0, "R1 no response after reset", {31'd0, resp_valid}, 32'd0);
    chk(mem_req === 1'b0, "R1 no read after reset", {31'd0, mem_req}, 32'd0);

    @(negedge clk);
    ctl_base_we = 1'b1; ctl_base = BASE | 32'h0000_0ABC;   // R13 low bits ignored
    @(negedge clk);
    ctl_base_we = 1'b0;

    xlate(32'h0040_1234, 0, 1, 32'h8000_1234, 0, 1, 1, "R5 R13 R1 section walk");
    xlate(32'h007F_FFF0, 0, 1, 32'h803F_FFF0, 0, 1, 0, "R2 R3 section hit");
    xlate(pva(5, 'h678), 0, 1, ppa(5, 'h678), 0, 0, 2, "R6 page walk");
    xlate(pva(5, 'h004), 0, 1, ppa(5, 'h004), 0, 0, 0, "R2 page hit");
    xlate(pva(6, 'h000), 0, 1, ppa(6, 'h000), 0, 1, 2, "R3 neighbour page misses");
    xlate(pva(5, 'h010), 0, 2, ppa(5, 'h010), 0, 0, 2, "R4 other asid misses");
    xlate(pva(3, 'h020), 0, 1, ppa(3, 'h020), 0, 0, 2, "R4 global walk");
    xlate(pva(3, 'h024), 0, 7, ppa(3, 'h024), 0, 0, 0, "R4 global hit any asid");
    xlate(32'h00C0_0000, 0, 1, 32'h0, 1, 0, 1, "R7 invalid first level");
    xlate(32'h00C0_0000, 0, 1, 32'h0, 1, 0, 1, "R7 not installed");
    xlate(32'h0086_4000, 0, 1, 32'h0, 1, 0, 2, "R7 invalid second level");
    xlate(pva(9, 'h100), 1, 1, 32'h0, 2, 0, 2, "R8 fetch no exec");
    xlate(pva(9, 'h104), 0, 1, ppa(9, 'h104), 0, 0, 0, "R8 data same page");
    xlate(pva(2, 'h008), 1, 1, ppa(2, 'h008), 0, 1, 2, "R8 fetch exec ok");
    // slots now: 0 sect,1 p5,2 p6,3 p5/asid2,4 p3,5 p9,6 p2; pointer at 7

    set_lock(0, 1'b1);
    flush_all();
    xlate(32'h0050_0000, 0, 1, 32'h8010_0000, 0, 1, 0, "R11 locked survives");
    xlate(pva(5, 'h000), 0, 1, ppa(5, 'h000), 0, 0, 2, "R11 unlocked flushed");
    // p5 in slot 7, pointer 8

    for (int i = 20; i < 28; i++) xlate(pva(i, 0), 0, 1, ppa(i, 0), 0, (i % 2 == 0), 2, "R9 fill");
    for (int i = 28; i < 34; i++) xlate(pva(i, 0), 0, 1, ppa(i, 0), 0, (i % 2 == 0), 2, "R9 wrap past lock");
    xlate(pva(5, 'h40), 0, 1, ppa(5, 'h40), 0, 0, 0, "R9 slot 7 not yet evicted");
    xlate(pva(34, 0), 0, 1, ppa(34, 0), 0, 1, 2, "R9 fill slot 7");
    xlate(pva(21, 0), 0, 1, ppa(21, 0), 0, 0, 0, "R9 slot 9 kept");
    xlate(pva(5, 'h44), 0, 1, ppa(5, 'h44), 0, 0, 2, "R9 slot 7 evicted");
    xlate(pva(20, 0), 0, 1, ppa(20, 0), 0, 1, 2, "R9 slot 8 evicted");
    // p20 now in slot 9

    for (int i = 0; i < 16; i++) set_lock(i, 1'b1);
    xlate(pva(40, 0), 0, 1, ppa(40, 0), 0, 1, 2, "R10 answer when full lock");
    xlate(pva(40, 4), 0, 1, ppa(40, 4), 0, 1, 2, "R10 nothing installed");
    flush_all();
    xlate(pva(20, 8), 0, 1, ppa(20, 8), 0, 1, 0, "R11 locked kept on flush");
    xlate(pva(5, 'h48), 0, 1, ppa(5, 'h48), 0, 0, 0, "R11 locked kept on flush");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 all responses seen", q.size(), 0);
    finish_run();
  end

endmodule